// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only, three-wire control port for a stereo playback path. An external controller frames each 16-bit control word with an active-low latch line. It shifts the word in most significant bit first on the rising edges of a serial clock. The serial clock may be free-running or gated, and it runs with no phase relation to the system clock. All three pins are brought into the system clock domain through synchronisers, so the serial clock must stay well below the system clock rate; 8 MHz against a 200 MHz system clock is the intended use.

When the latch rises, the word is committed only if exactly 16 serial clock edges arrived while it was low. The two least significant bits of the word select one of four destination registers: left channel volume, right channel volume, converter configuration, or clock configuration. The remaining bits are split into fields. Each field comes out on its own registered output. Reserved codes in the interpolation and sample-rate fields are refused field by field, and the rest of the same word is still accepted. A synchronous reset returns every field to its default and drops any frame that is partly shifted in.

Top module: `ctl_port_regs`

## Requirements
- R1: While the latch is low, each synchronised rising edge of the serial clock shifts one data bit in, most significant bit first, so the first bit sent becomes bit 15 of the word.
- R2: On a latch rising edge the word is committed only if exactly 16 serial clock edges were counted while the latch was low. With 15 or 17 edges the word is dropped, and no output changes.
- R3: Bits 1:0 of a committed word select the target: 00 left volume, 10 right volume, 01 converter configuration, 11 clock configuration. Registers that are not selected keep their values.
- R4: In a volume word, bits 15:2 are the 14-bit unsigned volume code, shown on `vol_left` or `vol_right`.
- R5: In a converter configuration word, the fields are: bits 11:10 interpolation (00 8x, 01 4x, 10 2x), bits 9:8 word width, bit 7 output invert, bit 6 soft mute, bits 5:4 serial format, and bits 3:2 de-emphasis. The code 11 in bits 11:10 leaves the interpolation output unchanged, while the other fields of that word are still written.
- R6: In a clock configuration word, the fields are: bits 11:9 power-down flags, bit 8 halve-all-clocks, bits 7:6 sample rate (00 48 kHz, 10 32 kHz, 11 44.1 kHz), bit 5 audio clock 384 select, bit 4 audio clock double, bit 3 DSP clock follows rate, and bit 2 master clock is an input. The code 01 in bits 7:6 leaves the rate output unchanged, while the other fields of that word are still written.
- R7: The edge counter restarts on every latch falling edge, so a proper frame that follows a dropped frame is committed normally.
- R8: While `rst` is high, both volumes become 0x3FFF and every other field becomes 0. The partial-frame edge count is cleared as well, so a frame that was in progress when reset arrived is never committed.
- R9: A committed word reaches the outputs no later than 6 system clocks after the latch pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sclk | input | 1 | Serial control clock, asynchronous |
| ctl_latch_n | input | 1 | Active-low frame latch, asynchronous |
| ctl_sdin | input | 1 | Serial control data |
| vol_left | output | 14 | Left volume code |
| vol_right | output | 14 | Right volume code |
| dac_interp | output | 2 | Interpolation factor code |
| dac_width | output | 2 | Serial word width code |
| dac_invert | output | 1 | Output phase invert |
| dac_mute | output | 1 | Soft mute |
| dac_format | output | 2 | Serial data format code |
| dac_deemph | output | 2 | De-emphasis select |
| clk_pwr_down | output | 3 | Clock generator power-down flags |
| clk_half | output | 1 | Halve all generated clocks |
| clk_rate | output | 2 | Sample rate code |
| clk_sclk1_384 | output | 1 | Audio clock 384 multiple select |
| clk_sclk1_dbl | output | 1 | Audio clock double select |
| clk_sclk2_fs | output | 1 | DSP clock tracks sample rate |
| clk_mclk_in | output | 1 | Master clock pin is an input |

## Verification
Two things can happen in the same commit cycle: a reserved code is refused and its field keeps the old value, while the legal fields of the same word are written. The bench provokes this with a configuration word that carries interpolation code 11 together with new width, format and de-emphasis values. It then checks that only the interpolation output kept its old value. It does the same with the clock word and rate code 01. A second overlap is reset against a partly shifted frame. Reset is pulsed halfway through a word, the rest of the bits and the latch edge are then sent, and the bench checks that the outputs still hold their reset values.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

  typedef struct packed {
    logic [1:0] interp;
    logic [1:0] width;
    logic       invert;
    logic       mute;
    logic [1:0] fmt;
    logic [1:0] deemph;
  } dac_cfg_t;

  typedef struct packed {
    logic [2:0] pwr_dn;
    logic       half;
    logic [1:0] rate;
    logic       sclk1_384;
    logic       sclk1_dbl;
    logic       sclk2_fs;
    logic       mclk_in;
  } clk_cfg_t;

  localparam logic [1:0] SEL_VOL_L = 2'b00;
  localparam logic [1:0] SEL_DAC   = 2'b01;
  localparam logic [1:0] SEL_VOL_R = 2'b10;
  localparam logic [1:0] SEL_CLK   = 2'b11;

  localparam logic [1:0] INTERP_BAD = 2'b11;
  localparam logic [1:0] RATE_BAD   = 2'b01;

endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {(STAGES+1){RST_VAL[i]}};
      else     pipe <= {pipe[STAGES-1:0], din[i]};
    end
    assign lvl[i]  = pipe[STAGES-1];
    assign rise[i] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[i] = ~pipe[STAGES-1] & pipe[STAGES];
  end

endmodule

// File: rtl/ctlp_shift.sv
module ctlp_shift #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              latch_lvl,
  input  logic              latch_rise,
  input  logic              latch_fall,
  input  logic              din,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_word,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
      wr_stb  <= 1'b0;
      wr_word <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (latch_fall) begin
        bit_cnt <= '0;
      end else if (sclk_rise && !latch_lvl) begin
        shreg <= {shreg[WORD_W-2:0], din};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (latch_rise) begin
        bit_cnt <= '0;
        if (bit_cnt == CNT_FULL) begin
          wr_stb  <= 1'b1;
          wr_word <= shreg;
        end
      end
    end
  end

endmodule

// File: rtl/ctlp_regs.sv
module ctlp_regs
  import ctlp_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SEL_W = 2,
  localparam int VOL_W = WORD_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  output logic [VOL_W-1:0]  vol_l,
  output logic [VOL_W-1:0]  vol_r,
  output dac_cfg_t          dac,
  output clk_cfg_t          clkc
);

  logic [SEL_W-1:0] sel;
  assign sel = wr_word[SEL_W-1:0];

  logic [VOL_W-1:0] vol_q [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_vol
    localparam logic [SEL_W-1:0] MY_SEL = (ch == 0) ? SEL_VOL_L : SEL_VOL_R;
    always_ff @(posedge clk) begin
      if (rst)                          vol_q[ch] <= '1;
      else if (wr_stb && sel == MY_SEL) vol_q[ch] <= wr_word[WORD_W-1:SEL_W];
    end
  end

  assign vol_l = vol_q[0];
  assign vol_r = vol_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dac <= '0;
    end else if (wr_stb && sel == SEL_DAC) begin
      if (wr_word[11:10] != INTERP_BAD) dac.interp <= wr_word[11:10];
      dac.width  <= wr_word[9:8];
      dac.invert <= wr_word[7];
      dac.mute   <= wr_word[6];
      dac.fmt    <= wr_word[5:4];
      dac.deemph <= wr_word[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkc <= '0;
    end else if (wr_stb && sel == SEL_CLK) begin
      clkc.pwr_dn <= wr_word[11:9];
      clkc.half   <= wr_word[8];
      if (wr_word[7:6] != RATE_BAD) clkc.rate <= wr_word[7:6];
      clkc.sclk1_384 <= wr_word[5];
      clkc.sclk1_dbl <= wr_word[4];
      clkc.sclk2_fs  <= wr_word[3];
      clkc.mclk_in   <= wr_word[2];
    end
  end

endmodule

// File: rtl/ctl_port_regs.sv
module ctl_port_regs
  import ctlp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_sclk,
  input  logic              ctl_latch_n,
  input  logic              ctl_sdin,
  output logic [WORD_W-3:0] vol_left,
  output logic [WORD_W-3:0] vol_right,
  output logic [1:0]        dac_interp,
  output logic [1:0]        dac_width,
  output logic              dac_invert,
  output logic              dac_mute,
  output logic [1:0]        dac_format,
  output logic [1:0]        dac_deemph,
  output logic [2:0]        clk_pwr_down,
  output logic              clk_half,
  output logic [1:0]        clk_rate,
  output logic              clk_sclk1_384,
  output logic              clk_sclk1_dbl,
  output logic              clk_sclk2_fs,
  output logic              clk_mclk_in
);

  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [2:0] pin_lvl, pin_rise, pin_fall;
  logic              wr_stb;
  logic [WORD_W-1:0] wr_word;
  logic [CNT_W-1:0]  bit_cnt;
  dac_cfg_t          dac;
  clk_cfg_t          clkc;

  // bit 0 serial clock, bit 1 latch (idles high), bit 2 data
  ctlp_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ctl_sdin, ctl_latch_n, ctl_sclk}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  ctlp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sclk_rise  (pin_rise[0]),
    .latch_lvl  (pin_lvl[1]),
    .latch_rise (pin_rise[1]),
    .latch_fall (pin_fall[1]),
    .din        (pin_lvl[2]),
    .wr_stb     (wr_stb),
    .wr_word    (wr_word),
    .bit_cnt    (bit_cnt)
  );

  ctlp_regs #(.WORD_W(WORD_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_word (wr_word),
    .vol_l   (vol_left),
    .vol_r   (vol_right),
    .dac     (dac),
    .clkc    (clkc)
  );

  assign dac_interp    = dac.interp;
  assign dac_width     = dac.width;
  assign dac_invert    = dac.invert;
  assign dac_mute      = dac.mute;
  assign dac_format    = dac.fmt;
  assign dac_deemph    = dac.deemph;
  assign clk_pwr_down  = clkc.pwr_dn;
  assign clk_half      = clkc.half;
  assign clk_rate      = clkc.rate;
  assign clk_sclk1_384 = clkc.sclk1_384;
  assign clk_sclk1_dbl = clkc.sclk1_dbl;
  assign clk_sclk2_fs  = clkc.sclk2_fs;
  assign clk_mclk_in   = clkc.mclk_in;

endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-3:0] vol_left,
  input logic [WORD_W-3:0] vol_right,
  input logic [1:0]        dac_interp,
  input logic [1:0]        clk_rate
);

  // R2: a commit only follows a full count of edges
  a_r2_commit_full: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(bit_cnt) == CNT_W'(WORD_W));

  // R4: volumes move only on a commit
  a_r4_vol_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(vol_left) && $stable(vol_right)));

  // R5: reserved interpolation code never appears
  a_r5_interp_legal: assert property (@(posedge clk) disable iff (rst)
    dac_interp != 2'b11);

  // R6: reserved rate code never appears
  a_r6_rate_legal: assert property (@(posedge clk) disable iff (rst)
    clk_rate != 2'b01);

  // R7: edge counter saturates one past a full word
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W + 1));

  // R8: reset loads defaults
  a_r8_defaults: assert property (@(posedge clk)
    rst |=> (vol_left == '1 && vol_right == '1 && dac_interp == 2'b00 && clk_rate == 2'b00 && bit_cnt == '0));

endmodule

bind ctl_port_regs ctl_port_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .bit_cnt    (bit_cnt),
  .vol_left   (vol_left),
  .vol_right  (vol_right),
  .dac_interp (dac_interp),
  .clk_rate   (clk_rate)
);

// File: tb/tb_ctl_port_regs.sv
`timescale 1ns/1ps
module tb_ctl_port_regs;

  localparam int HALF_SER = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_sclk = 1'b0;
  logic ctl_latch_n = 1'b1;
  logic ctl_sdin = 1'b0;
  logic [13:0] vol_left, vol_right;
  logic [1:0] dac_interp, dac_width, dac_format, dac_deemph, clk_rate;
  logic dac_invert, dac_mute, clk_half, clk_sclk1_384, clk_sclk1_dbl, clk_sclk2_fs, clk_mclk_in;
  logic [2:0] clk_pwr_down;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_port_regs dut (
    .clk(clk), .rst(rst), .ctl_sclk(ctl_sclk), .ctl_latch_n(ctl_latch_n), .ctl_sdin(ctl_sdin),
    .vol_left(vol_left), .vol_right(vol_right), .dac_interp(dac_interp), .dac_width(dac_width),
    .dac_invert(dac_invert), .dac_mute(dac_mute), .dac_format(dac_format), .dac_deemph(dac_deemph),
    .clk_pwr_down(clk_pwr_down), .clk_half(clk_half), .clk_rate(clk_rate),
    .clk_sclk1_384(clk_sclk1_384), .clk_sclk1_dbl(clk_sclk1_dbl), .clk_sclk2_fs(clk_sclk2_fs),
    .clk_mclk_in(clk_mclk_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame_open();
    ctl_latch_n = 1'b0;
    wait_clk(HALF_SER);
  endtask

  task automatic send_bits(input logic [15:0] w, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      ctl_sdin = w[(15 - i) & 15];
      wait_clk(HALF_SER);
      ctl_sclk = 1'b1;
      wait_clk(HALF_SER);
      ctl_sclk = 1'b0;
    end
  endtask

  task automatic frame_close();
    wait_clk(HALF_SER);
    ctl_latch_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic send_word(input logic [15:0] w, input int n);
    frame_open();
    send_bits(w, 0, n);
    frame_close();
  endtask

  task automatic t_reset();
    check("R8 vol_left default", vol_left, 14'h3FFF);
    check("R8 vol_right default", vol_right, 14'h3FFF);
    check("R8 dac fields default", {dac_interp, dac_width, dac_invert, dac_mute, dac_format, dac_deemph}, 0);
    check("R8 clk fields default", {clk_pwr_down, clk_half, clk_rate, clk_sclk1_384, clk_sclk1_dbl, clk_sclk2_fs, clk_mclk_in}, 0);
  endtask

  task automatic t_volume();
    send_word({14'h1234, 2'b00}, 16);
    check("R1 R4 left volume", vol_left, 14'h1234);
    check("R3 right untouched", vol_right, 14'h3FFF);
    send_word({14'h0ABC, 2'b10}, 16);
    check("R3 R4 right volume", vol_right, 14'h0ABC);
    check("R3 left untouched", vol_left, 14'h1234);
  endtask

  task automatic t_latency();
    frame_open();
    send_bits({14'h2001, 2'b00}, 0, 16);
    wait_clk(HALF_SER);
    ctl_latch_n = 1'b1;
    wait_clk(6);
    check("R9 latency six clocks", vol_left, 14'h2001);
  endtask

  task automatic t_dac();
    send_word(16'h06F9, 16);
    check("R5 dac fields", {dac_interp, dac_width, dac_invert, dac_mute, dac_format, dac_deemph}, 12'b01_10_1_1_11_10);
    check("R3 clk untouched", {clk_pwr_down, clk_rate}, 0);
    send_word(16'h0D2D, 16);
    check("R5 interp kept on reserved code", dac_interp, 2'b01);
    check("R5 other dac fields written", {dac_width, dac_invert, dac_mute, dac_format, dac_deemph}, 10'b01_0_0_10_11);
  endtask

  task automatic t_clk();
    send_word(16'h0BAF, 16);
    check("R6 clk fields", {clk_pwr_down, clk_half, clk_rate, clk_sclk1_384, clk_sclk1_dbl, clk_sclk2_fs, clk_mclk_in}, 12'b101_1_10_1_0_1_1);
    send_word(16'h0043, 16);
    check("R6 rate kept on reserved code", clk_rate, 2'b10);
    check("R6 other clk fields written", {clk_pwr_down, clk_half, clk_sclk1_384, clk_sclk1_dbl, clk_sclk2_fs, clk_mclk_in}, 0);
  endtask

  task automatic t_bad_count();
    send_word({14'h0111, 2'b00}, 15);
    check("R2 fifteen edges dropped", vol_left, 14'h2001);
    send_word({14'h0222, 2'b00}, 17);
    check("R2 seventeen edges dropped", vol_left, 14'h2001);
    send_word({14'h0333, 2'b00}, 16);
    check("R7 frame after dropped frame", vol_left, 14'h0333);
  endtask

  task automatic t_reset_mid_frame();
    frame_open();
    send_bits({14'h0444, 2'b10}, 0, 8);
    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    send_bits({14'h0444, 2'b10}, 8, 8);
    frame_close();
    check("R8 reset restores left", vol_left, 14'h3FFF);
    check("R8 partial frame not committed", vol_right, 14'h3FFF);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    t_reset();
    t_volume();
    t_latency();
    t_dac();
    t_clk();
    t_bad_count();
    t_reset_mid_frame();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        wait_clk(150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule